// File: doc/BRIEF.md
# Self-Relocating I/O Base Decoder

This block claims host bus accesses that fall inside a 32-byte window whose base is one of eight fixed I/O addresses. A configuration byte arrives serially from an external EEPROM after reset. Its low three bits pick the base. Its top two bits pick which of four interrupt output pins carries the internal interrupt request. The first eight offsets of the window return a fixed signature, so host software can tell whether the block answers at the address it probed.

Once the byte is loaded, the three base bits act as a counter. Each host read of the advance register (offset 0x12) moves the window to the next base after that read completes. Software therefore probes, reads the advance register, and probes again until it finds a free slot. It then clears the counting bit (bit 7 of the control register at offset 0x0D) to freeze the base. Offset 0x13 reads back the live configuration byte, so the chosen setting can be stored again.

The loader state machine has three states. LD_WAIT moves to LD_SHIFT on the first serial strobe. LD_SHIFT moves to LD_READY when the eighth strobe arrives. LD_READY is terminal. The mode state machine has two states. MODE_LOCKED is the reset state. MODE_COUNT is entered when the load completes or when a 1 is written to control bit 7. Writing a 0 to control bit 7 returns the machine to MODE_LOCKED.

Top module: `iobase_relocator`

## Requirements
- R1: While reset is asserted and after it is released, `load_done` is 0, `hit` is 0, `rdata` is 0 and all `irq_out` bits are 0, until a load completes.
- R2: Each cycle with `ee_shift` high shifts `ee_bit` into the configuration byte, MSB first. The cycle after the eighth strobe, `load_done` is 1 and offset 0x13 reads that byte. Later strobes change nothing.
- R3: `hit` is 1 exactly when `load_done` is 1, `rd` or `wr` is high, and `addr` lies in [B, B+31], where B = 0x260 + 0x20 × cfg[2:0]. Accesses made before the load completes have no effect.
- R4: A read hit at offset i, with i from 0 to 7, returns 0x30 + 0x11 × i.
- R5: After the load, control offset 0x0D reads 0x80 (counting). In counting mode, a read hit at offset 0x12 returns {5'b0, index}, where index is the value before the increment. From the next cycle on, the index is one higher.
- R6: The index wraps from 7 to 0. The window then sits at 0x260 again.
- R7: A write hit at offset 0x0D sets the mode from `wdata[7]`: 0 selects locked, 1 selects counting. The register reads {mode, 7'b0}. In locked mode, reads of offset 0x12 leave the index unchanged.
- R8: A read hit at offset 0x13 returns the whole configuration byte, including the current index. Any other offset reads 0. `rdata` is 0 whenever there is no read hit.
- R9: After the load, `irq_out[cfg[7:6]]` equals `irq_req` and the other three lines are 0. Before the load, all four lines are 0.
- R10: Writes to offsets other than 0x0D, and accesses that miss the window, leave the configuration and mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_shift | input | 1 | Serial configuration bit strobe |
| ee_bit | input | 1 | Serial configuration data, MSB first |
| addr | input | 10 | Host I/O address |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe (ignored when rd is high) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational |
| hit | output | 1 | Access claimed by this block |
| load_done | output | 1 | Configuration byte loaded |
| irq_req | input | 1 | Internal interrupt request |
| irq_out | output | 4 | Steered interrupt lines |

## Verification
A wrong index register shows up on the very next access. The window moves, so `hit` rises at the wrong addresses, and the signature reads and offset 0x13 show a shifted byte. An increment that is missed, doubled or fires in locked mode becomes visible on the following probe, one cycle after the advance read. A wrong mode state only shows when the next advance read follows, or through a read of offset 0x0D. A wrong interrupt selection shows at once on `irq_out` while `irq_req` toggles.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    localparam int ADDR_W   = 10;
    localparam int CFG_W    = 8;
    localparam int IDX_W    = 3;
    localparam int WIN      = 32;
    localparam int OFF_W    = $clog2(WIN);
    localparam int IRQ_N    = 4;
    localparam int SIG_N    = 8;

    localparam logic [ADDR_W-1:0] BASE0  = 10'h260;
    localparam logic [ADDR_W-1:0] STRIDE = 10'h020;

    localparam logic [OFF_W-1:0] OFF_CTRL = 5'h0D;
    localparam logic [OFF_W-1:0] OFF_ADV  = 5'h12;
    localparam logic [OFF_W-1:0] OFF_CFG  = 5'h13;

    typedef enum logic [1:0] {LD_WAIT, LD_SHIFT, LD_READY} ld_state_t;
    typedef enum logic {MODE_LOCKED, MODE_COUNT} mode_t;

    function automatic logic [7:0] sig_byte(input logic [OFF_W-1:0] i);
        return 8'h30 + 8'h11 * {3'b000, i};
    endfunction
endpackage

// File: rtl/reloc_loader.sv
module reloc_loader
    import reloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ee_shift,
    input  logic             ee_bit,
    output logic             load_fire,
    output logic [CFG_W-1:0] load_byte,
    output logic             load_done
);
    localparam int CNT_W = $clog2(CFG_W);

    ld_state_t        state, state_nx;
    logic [CFG_W-1:0] sreg;
    logic [CNT_W-1:0] bitcnt;
    logic             last_bit;

    assign last_bit = (bitcnt == CNT_W'(CFG_W - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_WAIT:  if (ee_shift) state_nx = last_bit ? LD_READY : LD_SHIFT;
            LD_SHIFT: if (ee_shift && last_bit) state_nx = LD_READY;
            LD_READY: state_nx = LD_READY;
            default:  state_nx = LD_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LD_WAIT;
            sreg   <= '0;
            bitcnt <= '0;
        end else begin
            state <= state_nx;
            if (ee_shift && state != LD_READY) begin
                sreg   <= {sreg[CFG_W-2:0], ee_bit};
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    always_comb begin
        load_fire = ee_shift && last_bit && (state != LD_READY);
        load_byte = {sreg[CFG_W-2:0], ee_bit};
        load_done = (state == LD_READY);
    end

    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);
    // R2
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> load_done);
endmodule

// File: rtl/reloc_decode.sv
module reloc_decode
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              load_done,
    input  logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic [OFF_W-1:0]  offset
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] delta;
    logic              in_win;

    always_comb begin
        base   = BASE0 + STRIDE * {{(ADDR_W-IDX_W){1'b0}}, idx};
        delta  = addr - base;
        in_win = (addr >= base) && (delta < ADDR_W'(WIN));
        offset = delta[OFF_W-1:0];
        hit    = load_done && (rd || wr) && in_win;
    end

    // R3
    hit_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> load_done);
    // R3
    hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rd || wr));
endmodule

// File: rtl/reloc_regs.sv
module reloc_regs
    import reloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_fire,
    input  logic [CFG_W-1:0] load_byte,
    input  logic             hit,
    input  logic             rd,
    input  logic             wr,
    input  logic [OFF_W-1:0] offset,
    input  logic [7:0]       wdata,
    output logic [CFG_W-1:0] cfg,
    output logic [7:0]       rdata
);
    mode_t mode;
    logic  rd_hit, wr_hit, advance;

    assign rd_hit  = hit && rd;
    assign wr_hit  = hit && wr && !rd;
    assign advance = rd_hit && (offset == OFF_ADV) && (mode == MODE_COUNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_LOCKED;
            cfg  <= '0;
        end else if (load_fire) begin
            mode <= MODE_COUNT;
            cfg  <= load_byte;
        end else begin
            if (advance)
                cfg[IDX_W-1:0] <= cfg[IDX_W-1:0] + 1'b1;
            if (wr_hit && offset == OFF_CTRL)
                mode <= wdata[7] ? MODE_COUNT : MODE_LOCKED;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            if (offset < OFF_W'(SIG_N))
                rdata = sig_byte(offset);
            else if (offset == OFF_CTRL)
                rdata = {(mode == MODE_COUNT), 7'b0};
            else if (offset == OFF_ADV)
                rdata = {{(8-IDX_W){1'b0}}, cfg[IDX_W-1:0]};
            else if (offset == OFF_CFG)
                rdata = cfg;
        end
    end

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_fire) |=> cfg[IDX_W-1:0] == IDX_W'($past(cfg[IDX_W-1:0]) + 1'b1));
    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCKED && !load_fire) |=> $stable(cfg));
    // R10
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fire |=> $stable(cfg[CFG_W-1:IDX_W]));
endmodule

// File: rtl/reloc_irq_steer.sv
module reloc_irq_steer
    import reloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_done,
    input  logic [1:0]       sel,
    input  logic             irq_req,
    output logic [IRQ_N-1:0] irq_out
);
    for (genvar g = 0; g < IRQ_N; g++) begin : g_line
        assign irq_out[g] = load_done && irq_req && (sel == 2'(g));
    end

    // R9
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out));
    // R9
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_out == '0);
endmodule

// File: rtl/iobase_relocator.sv
module iobase_relocator
    import reloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ee_shift,
    input  logic             ee_bit,
    input  logic [ADDR_W-1:0] addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             hit,
    output logic             load_done,
    input  logic             irq_req,
    output logic [IRQ_N-1:0] irq_out
);
    logic             load_fire;
    logic [CFG_W-1:0] load_byte;
    logic [CFG_W-1:0] cfg;
    logic [OFF_W-1:0] offset;

    reloc_loader u_loader (
        .clk(clk), .rst_n(rst_n), .ee_shift(ee_shift), .ee_bit(ee_bit),
        .load_fire(load_fire), .load_byte(load_byte), .load_done(load_done)
    );

    reloc_decode u_decode (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .load_done(load_done), .idx(cfg[IDX_W-1:0]), .hit(hit), .offset(offset)
    );

    reloc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .load_byte(load_byte),
        .hit(hit), .rd(rd), .wr(wr), .offset(offset), .wdata(wdata),
        .cfg(cfg), .rdata(rdata)
    );

    reloc_irq_steer u_irq (
        .clk(clk), .rst_n(rst_n), .load_done(load_done), .sel(cfg[7:6]),
        .irq_req(irq_req), .irq_out(irq_out)
    );

    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && rd) |-> rdata == 8'h00);
endmodule

// File: tb/sim_iobase_relocator.sv
module sim_iobase_relocator;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ee_shift = 0, ee_bit = 0;
    logic [9:0] addr = 0;
    logic       rd = 0, wr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       hit, load_done;
    logic       irq_req = 0;
    logic [3:0] irq_out;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [7:0] m_cfg;
    bit         m_count;

    always #5 clk = ~clk;

    iobase_relocator u0 (
        .clk(clk), .rst_n(rst_n), .ee_shift(ee_shift), .ee_bit(ee_bit),
        .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
        .hit(hit), .load_done(load_done), .irq_req(irq_req), .irq_out(irq_out)
    );

    function automatic logic [9:0] base_of(input logic [2:0] i);
        return 10'h260 + 10'(i) * 10'h20;
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] off);
        if (off < 5'd8) return 8'h30 + 8'd17 * 8'(off);
        if (off == 5'h0D) return {m_count, 7'b0};
        if (off == 5'h12) return {5'b0, m_cfg[2:0]};
        if (off == 5'h13) return m_cfg;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [9:0] a, output logic [7:0] d, output logic h);
        @(negedge clk); addr = a; rd = 1; wr = 0;
        #1; d = rdata; h = hit;
        @(negedge clk); rd = 0;
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] v, output logic h);
        @(negedge clk); addr = a; wr = 1; rd = 0; wdata = v;
        #1; h = hit;
        @(negedge clk); wr = 0;
    endtask

    task automatic model_read(input logic [4:0] off);
        logic [7:0] d; logic h;
        do_read(base_of(m_cfg[2:0]) + 10'(off), d, h);
        chk(h == 1, "R3 read hit", h, 1);
        if (off < 5'd8) chk(d == exp_read(off), "R4 signature", d, exp_read(off));
        else if (off == 5'h12) chk(d == exp_read(off), "R5 advance data", d, exp_read(off));
        else if (off == 5'h0D) chk(d == exp_read(off), "R7 control", d, exp_read(off));
        else chk(d == exp_read(off), "R8 readback", d, exp_read(off));
        if (off == 5'h12 && m_count) m_cfg[2:0] = m_cfg[2:0] + 3'd1;
    endtask

    task automatic load_cfg(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); ee_shift = 1; ee_bit = b[i];
        end
        @(negedge clk); ee_shift = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic h;
        int seed;
        seed = $urandom(32'h1D0BA5E);
        repeat (3) @(negedge clk);
        // R1
        chk(load_done == 0 && hit == 0 && irq_out == 0 && rdata == 0, "R1 reset", {load_done, hit, irq_out}, 0);
        rst_n = 1;
        irq_req = 1;
        do_read(10'h260, d, h);
        chk(h == 0 && d == 0, "R3 pre-load ignored", {h, d}, 0);
        chk(irq_out == 0, "R9 pre-load lines", irq_out, 0);
        do_write(10'h26D, 8'h00, h);
        chk(h == 0, "R1 no hit before load", h, 0);

        load_cfg(8'b10_101_110);
        m_cfg = 8'b10_101_110; m_count = 1;
        chk(load_done == 1, "R2 load_done", load_done, 1);
        // R2: extra strobes ignored
        load_cfg(8'hFF);
        model_read(5'h13);
        model_read(5'h0D);
        #1; chk(irq_out == 4'b0100, "R9 steer", irq_out, 4'b0100);

        // R5/R6: advance through wrap
        for (int k = 0; k < 3; k++) model_read(5'h12);
        chk(m_cfg[2:0] == 3'd1, "R6 model wrap", m_cfg[2:0], 1);
        do_read(10'h260 + 10'h20, d, h);
        chk(h == 1 && d == 8'h30, "R6 window after wrap", d, 8'h30);
        do_read(10'h2E0, d, h);
        chk(h == 0, "R3 old window dead", h, 0);

        // R7 lock
        do_write(base_of(m_cfg[2:0]) + 10'h0D, 8'h7F, h); m_count = 0;
        chk(h == 1, "R7 write hit", h, 1);
        model_read(5'h12); model_read(5'h12);
        model_read(5'h13); model_read(5'h0D);
        do_write(base_of(m_cfg[2:0]) + 10'h0D, 8'h80, h); m_count = 1;
        model_read(5'h12); model_read(5'h13);

        // R10 writes elsewhere
        do_write(base_of(m_cfg[2:0]) + 10'h13, 8'h00, h);
        do_write(base_of(m_cfg[2:0]) + 10'h12, 8'h00, h);
        model_read(5'h13);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom % 5;
            irq_req = $urandom % 2;
            if (op == 0) model_read(5'($urandom % 32));
            else if (op == 1) begin
                logic [9:0] a; logic ex;
                a = 10'($urandom);
                do_read(a, d, h);
                ex = (a >= base_of(m_cfg[2:0])) && (a < base_of(m_cfg[2:0]) + 10'd32);
                chk(h == ex, "R3 random decode", h, ex);
                if (ex && a - base_of(m_cfg[2:0]) == 10'h12 && m_count) m_cfg[2:0] = m_cfg[2:0] + 3'd1;
                if (!ex) chk(d == 0, "R8 miss data", d, 0);
            end else if (op == 2) begin
                logic [7:0] v; v = 8'($urandom);
                do_write(base_of(m_cfg[2:0]) + 10'h0D, v, h);
                m_count = v[7];
            end else if (op == 3) begin
                logic [4:0] o; o = 5'($urandom);
                if (o == 5'h0D) o = 5'h0E;
                do_write(base_of(m_cfg[2:0]) + 10'(o), 8'($urandom), h);
                chk(h == 1, "R10 write hit", h, 1);
            end else begin
                @(negedge clk); #1;
                chk(irq_out == (irq_req ? 4'b0100 : 4'b0000), "R9 random irq", irq_out, irq_req ? 4 : 0);
            end
        end
        model_read(5'h13);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule